// File: doc/BRIEF.md
# Decode-Stage Branch Resolution Controller

This block is the control-hazard logic of a five-stage in-order pipeline that settles conditional branches and jumps while they sit in the decode stage. It compares the two branch source operands for equality. Before the compare, each operand can be replaced by the result now held in the EX/MEM register. The block also spots the one case forwarding cannot cover: the instruction directly ahead, now in ID/EX, produces a branch operand. In that case it asks for a one-cycle hold.

For a taken branch or a jump, the block discards the one wrong-path instruction that was fetched. It also picks where the next PC comes from and supplies the redirect address. The branch-target adder runs for every instruction, whether or not a branch is taken.

Results written back from MEM/WB need no path here, because the register file writes before it reads within a cycle. The register file, ALU and memories are outside the block.

Top module: `brc_ctrl`

## Requirements
- R1: `fwd_a` is 1 exactly when `mem_wen` is 1, `mem_dst` is nonzero and `mem_dst` equals `id_rs`. `fwd_b` follows the same rule against `id_rt`. The two selects are decided independently. When a select is 1, that comparator input takes `mem_result` instead of the register-file value.
- R2: Register zero is never a hazard source. A zero `mem_dst` never sets a forward select. A zero `ex_dst` never raises `stall`.
- R3: `stall` is 1 exactly when all of these hold:
  - the decode instruction is a conditional branch (`id_beq` or `id_bne`);
  - `ex_wen` is 1;
  - `ex_dst` is nonzero;
  - `ex_dst` equals `id_rs` or `id_rt`.
  Jumps and non-branch instructions never stall. A `stall` of 1 means: hold the PC and IF/ID, and zero the ID/EX control bits.
- R4: The comparison uses the operands after forwarding. A `beq` is taken when they are equal. A `bne` is taken when they differ.
- R5: A taken branch without a stall gives `if_flush`=1 and `pc_sel`=1. `redirect_pc` is then `id_pc4` plus the sign-extended 16-bit `id_imm` shifted left by two.
- R6: A jump gives `if_flush`=1 and `pc_sel`=2. `redirect_pc` is then {`id_pc4`[31:28], `id_jidx`, 2'b00}. If both a jump flag and a branch flag are set, the jump wins.
- R7: When `stall` is 1, `if_flush` is 0 and `pc_sel` is 0, even if the comparator would take the branch. The branch is evaluated again on the next cycle.
- R8: When there is no jump, no taken branch and no stall, `if_flush` is 0 and `pc_sel` is 0, which selects sequential PC+4.
- R9: Whenever no jump flag is set, `redirect_pc` carries the branch target of the decode instruction. This holds for non-branch instructions too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the embedded checks) |
| rst | input | 1 | Synchronous active-high reset |
| id_pc4 | input | 32 | PC+4 of the instruction in decode |
| id_rs | input | 5 | First source register number |
| id_rt | input | 5 | Second source register number |
| id_rs_val | input | 32 | Register-file read data for id_rs |
| id_rt_val | input | 32 | Register-file read data for id_rt |
| id_imm | input | 16 | Branch offset field |
| id_jidx | input | 26 | Jump index field |
| id_beq | input | 1 | Decode holds branch-if-equal |
| id_bne | input | 1 | Decode holds branch-if-not-equal |
| id_jump | input | 1 | Decode holds an unconditional jump |
| ex_wen | input | 1 | Instruction in ID/EX writes a register |
| ex_dst | input | 5 | Destination register of the ID/EX instruction |
| mem_wen | input | 1 | Instruction in EX/MEM writes a register |
| mem_dst | input | 5 | Destination register of the EX/MEM instruction |
| mem_result | input | 32 | Result held in EX/MEM |
| fwd_a | output | 1 | Comparator input A takes mem_result |
| fwd_b | output | 1 | Comparator input B takes mem_result |
| stall | output | 1 | Hold PC and IF/ID, insert an ID/EX bubble |
| if_flush | output | 1 | Zero the IF/ID instruction field |
| pc_sel | output | 2 | Next PC: 0 sequential, 1 branch target, 2 jump target |
| redirect_pc | output | 32 | Jump target when id_jump, else branch target |

## Verification
Each operand pattern is chosen to separate one path from the others.
- Equal and unequal operands, tried under both `beq` and `bne`, separate the comparator polarity.
- Forwarding is tried on one operand, on both, and with a zero destination. This shows the selects are independent and that register zero is never forwarded.
- A branch whose raw register values differ but whose forwarded values are equal is taken only if the forwarded operand is actually used.
- An ID/EX producer that matches a branch source is applied with the write enable on and off, and under a jump. This separates a true stall from a spurious one, and shows the stall overrides a would-be-taken branch.
- Positive and negative offsets, a jump field with high bits set, and a non-branch instruction check the target arithmetic and that the target is always present.

// File: rtl/brc_pkg.sv
package brc_pkg;

    typedef enum logic [1:0] {
        NPC_SEQ    = 2'd0,
        NPC_BRANCH = 2'd1,
        NPC_JUMP   = 2'd2
    } npc_sel_e;

    typedef struct packed {
        logic is_beq;
        logic is_bne;
        logic is_jump;
    } flow_ctl_t;

    function automatic logic is_cond_branch(input flow_ctl_t c);
        return c.is_beq | c.is_bne;
    endfunction

endpackage

// File: rtl/brc_fwd_unit.sv
module brc_fwd_unit
    import brc_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int REG_W = 5,
    parameter int NSRC  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NSRC-1:0][REG_W-1:0] src_reg,
    input  logic [NSRC-1:0][XLEN-1:0]  rf_val,
    input  logic                       mem_wen,
    input  logic [REG_W-1:0]           mem_dst,
    input  logic [XLEN-1:0]            mem_val,
    output logic [NSRC-1:0]            fwd_sel,
    output logic [NSRC-1:0][XLEN-1:0]  opnd
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic mem_live;
    assign mem_live = mem_wen && (mem_dst != ZERO_REG);

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        always_comb begin
            fwd_sel[i] = mem_live && (mem_dst == src_reg[i]);
            opnd[i]    = fwd_sel[i] ? mem_val : rf_val[i];
        end

        // R2
        zero_reg_fwd_chk: assert property (@(posedge clk) disable iff (rst)
            (mem_dst == ZERO_REG) |-> !fwd_sel[i]);

        // R1
        fwd_operand_chk: assert property (@(posedge clk) disable iff (rst)
            fwd_sel[i] |-> (opnd[i] == mem_val));
    end

endmodule

// File: rtl/brc_hazard.sv
module brc_hazard
    import brc_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int NSRC  = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  flow_ctl_t                  ctl,
    input  logic [NSRC-1:0][REG_W-1:0] src_reg,
    input  logic                       ex_wen,
    input  logic [REG_W-1:0]           ex_dst,
    output logic                       stall
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic [NSRC-1:0] src_hit;

    for (genvar i = 0; i < NSRC; i++) begin : g_hit
        assign src_hit[i] = (src_reg[i] == ex_dst);
    end

    always_comb begin
        stall = is_cond_branch(ctl) && ex_wen && (ex_dst != ZERO_REG) && (|src_hit);
    end

    // R3
    stall_only_branch_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> (ctl.is_beq || ctl.is_bne));

endmodule

// File: rtl/brc_resolve.sv
module brc_resolve
    import brc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int IMM_W  = 16,
    parameter int JIDX_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  flow_ctl_t         ctl,
    input  logic              stall,
    input  logic [XLEN-1:0]   opnd_a,
    input  logic [XLEN-1:0]   opnd_b,
    input  logic [XLEN-1:0]   pc4,
    input  logic [IMM_W-1:0]  imm,
    input  logic [JIDX_W-1:0] jidx,
    output logic              flush,
    output npc_sel_e          npc_sel,
    output logic [XLEN-1:0]   redirect
);
    localparam int SEXT_W = XLEN - IMM_W - 2;
    localparam int JHI_W  = XLEN - JIDX_W - 2;

    logic            same;
    logic            taken;
    logic [XLEN-1:0] br_off;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] j_tgt;

    always_comb begin
        br_off = {{SEXT_W{imm[IMM_W-1]}}, imm, 2'b00};
        br_tgt = pc4 + br_off;
        j_tgt  = {pc4[XLEN-1 -: JHI_W], jidx, 2'b00};
        same   = (opnd_a == opnd_b);
        taken  = (ctl.is_beq && same) || (ctl.is_bne && !same);
    end

    always_comb begin
        flush    = 1'b0;
        npc_sel  = NPC_SEQ;
        redirect = ctl.is_jump ? j_tgt : br_tgt;
        if (!stall) begin
            if (ctl.is_jump) begin
                flush   = 1'b1;
                npc_sel = NPC_JUMP;
            end else if (taken) begin
                flush   = 1'b1;
                npc_sel = NPC_BRANCH;
            end
        end
    end

    // R7
    stall_no_flush_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> (!flush && npc_sel == NPC_SEQ));

    // R6
    jump_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl.is_jump && !stall) |-> (flush && npc_sel == NPC_JUMP));

    // R5
    flush_redirect_chk: assert property (@(posedge clk) disable iff (rst)
        flush |-> (npc_sel != NPC_SEQ));

endmodule

// File: rtl/brc_ctrl.sv
module brc_ctrl
    import brc_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int REG_W  = 5,
    parameter int IMM_W  = 16,
    parameter int JIDX_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [XLEN-1:0]   id_pc4,
    input  logic [REG_W-1:0]  id_rs,
    input  logic [REG_W-1:0]  id_rt,
    input  logic [XLEN-1:0]   id_rs_val,
    input  logic [XLEN-1:0]   id_rt_val,
    input  logic [IMM_W-1:0]  id_imm,
    input  logic [JIDX_W-1:0] id_jidx,
    input  logic              id_beq,
    input  logic              id_bne,
    input  logic              id_jump,
    input  logic              ex_wen,
    input  logic [REG_W-1:0]  ex_dst,
    input  logic              mem_wen,
    input  logic [REG_W-1:0]  mem_dst,
    input  logic [XLEN-1:0]   mem_result,
    output logic              fwd_a,
    output logic              fwd_b,
    output logic              stall,
    output logic              if_flush,
    output logic [1:0]        pc_sel,
    output logic [XLEN-1:0]   redirect_pc
);
    localparam int NSRC = 2;

    flow_ctl_t                  ctl;
    logic [NSRC-1:0][REG_W-1:0] src_reg;
    logic [NSRC-1:0][XLEN-1:0]  rf_val;
    logic [NSRC-1:0]            fwd_sel;
    logic [NSRC-1:0][XLEN-1:0]  opnd;
    npc_sel_e                   npc_sel;

    always_comb begin
        ctl.is_beq  = id_beq;
        ctl.is_bne  = id_bne;
        ctl.is_jump = id_jump;
        src_reg[0]  = id_rs;
        src_reg[1]  = id_rt;
        rf_val[0]   = id_rs_val;
        rf_val[1]   = id_rt_val;
    end

    brc_fwd_unit #(.XLEN(XLEN), .REG_W(REG_W), .NSRC(NSRC)) u_fwd (
        .clk     (clk),
        .rst     (rst),
        .src_reg (src_reg),
        .rf_val  (rf_val),
        .mem_wen (mem_wen),
        .mem_dst (mem_dst),
        .mem_val (mem_result),
        .fwd_sel (fwd_sel),
        .opnd    (opnd)
    );

    brc_hazard #(.REG_W(REG_W), .NSRC(NSRC)) u_haz (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .src_reg (src_reg),
        .ex_wen  (ex_wen),
        .ex_dst  (ex_dst),
        .stall   (stall)
    );

    brc_resolve #(.XLEN(XLEN), .IMM_W(IMM_W), .JIDX_W(JIDX_W)) u_res (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .stall    (stall),
        .opnd_a   (opnd[0]),
        .opnd_b   (opnd[1]),
        .pc4      (id_pc4),
        .imm      (id_imm),
        .jidx     (id_jidx),
        .flush    (if_flush),
        .npc_sel  (npc_sel),
        .redirect (redirect_pc)
    );

    assign fwd_a  = fwd_sel[0];
    assign fwd_b  = fwd_sel[1];
    assign pc_sel = npc_sel;

    // R2
    zero_ex_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (ex_dst == '0) |-> !stall);

    // R8
    quiet_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (!id_beq && !id_bne && !id_jump) |-> (!if_flush && pc_sel == 2'd0));

endmodule

// File: tb/tb_brc_ctrl.sv
module tb_brc_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] id_pc4, id_rs_val, id_rt_val, mem_result;
    logic [4:0]  id_rs, id_rt, ex_dst, mem_dst;
    logic [15:0] id_imm;
    logic [25:0] id_jidx;
    logic        id_beq, id_bne, id_jump, ex_wen, mem_wen;
    logic        fwd_a, fwd_b, stall, if_flush;
    logic [1:0]  pc_sel;
    logic [31:0] redirect_pc;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    brc_ctrl dut (.*);

    task automatic chk(input string req, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, got, exp);
        end
    endtask

    task automatic idle();
        id_pc4 = 32'h0000_1004; id_rs = 0; id_rt = 0; id_rs_val = 0; id_rt_val = 0;
        id_imm = 0; id_jidx = 0; id_beq = 0; id_bne = 0; id_jump = 0;
        ex_wen = 0; ex_dst = 0; mem_wen = 0; mem_dst = 0; mem_result = 0;
    endtask

    task automatic settle();
        #5;
    endtask

    task automatic t_reset_idle();
        @(negedge clk); idle(); settle();
        chk("R8", "idle flush", {31'd0, if_flush}, 0);
        chk("R8", "idle pc_sel", {30'd0, pc_sel}, 0);
        chk("R3", "idle stall", {31'd0, stall}, 0);
        chk("R1", "idle fwd", {30'd0, fwd_a, fwd_b}, 0);
    endtask

    task automatic t_forward_selects();
        @(negedge clk); idle();
        mem_wen = 1; mem_dst = 5'd3; id_rs = 5'd3; id_rt = 5'd4; settle();
        chk("R1", "fwd a only", {30'd0, fwd_a, fwd_b}, 32'h2);
        @(negedge clk); id_rs = 5'd4; id_rt = 5'd3; settle();
        chk("R1", "fwd b only", {30'd0, fwd_a, fwd_b}, 32'h1);
        @(negedge clk); id_rs = 5'd3; settle();
        chk("R1", "fwd both", {30'd0, fwd_a, fwd_b}, 32'h3);
        @(negedge clk); mem_wen = 0; settle();
        chk("R1", "fwd no wen", {30'd0, fwd_a, fwd_b}, 0);
    endtask

    task automatic t_zero_reg();
        @(negedge clk); idle();
        mem_wen = 1; mem_dst = 0; id_rs = 0; id_rt = 0; settle();
        chk("R2", "r0 fwd", {30'd0, fwd_a, fwd_b}, 0);
        @(negedge clk); id_beq = 1; ex_wen = 1; ex_dst = 0; settle();
        chk("R2", "r0 stall", {31'd0, stall}, 0);
    endtask

    task automatic t_compare_forwarded();
        @(negedge clk); idle();
        id_beq = 1; id_rs = 5'd5; id_rt = 5'd6; id_rs_val = 32'd10; id_rt_val = 32'd7;
        id_imm = 16'h0003; settle();
        chk("R4", "beq unequal not taken", {31'd0, if_flush}, 0);
        @(negedge clk); mem_wen = 1; mem_dst = 5'd6; mem_result = 32'd10; settle();
        chk("R4", "beq fwd equal flush", {31'd0, if_flush}, 1);
        chk("R5", "beq pc_sel", {30'd0, pc_sel}, 1);
        chk("R5", "beq target pos", redirect_pc, 32'h0000_1010);
        @(negedge clk); id_imm = 16'hFFFE; settle();
        chk("R5", "beq target neg", redirect_pc, 32'h0000_0FFC);
        @(negedge clk); id_beq = 0; id_bne = 1; settle();
        chk("R4", "bne equal not taken", {31'd0, if_flush}, 0);
        chk("R8", "bne not taken pc_sel", {30'd0, pc_sel}, 0);
        @(negedge clk); mem_wen = 0; settle();
        chk("R4", "bne unequal taken", {30'd0, pc_sel}, 1);
    endtask

    task automatic t_stall_priority();
        @(negedge clk); idle();
        id_beq = 1; id_rs = 5'd7; id_rt = 5'd8; id_rs_val = 32'h55; id_rt_val = 32'h55;
        ex_wen = 1; ex_dst = 5'd8; settle();
        chk("R3", "stall on rt", {31'd0, stall}, 1);
        chk("R7", "stall blocks flush", {31'd0, if_flush}, 0);
        chk("R7", "stall pc_sel", {30'd0, pc_sel}, 0);
        @(negedge clk); ex_dst = 5'd7; settle();
        chk("R3", "stall on rs", {31'd0, stall}, 1);
        @(negedge clk); ex_wen = 0; settle();
        chk("R3", "no wen no stall", {31'd0, stall}, 0);
        chk("R7", "released branch taken", {31'd0, if_flush}, 1);
        @(negedge clk); ex_wen = 1; id_beq = 0; id_jump = 1; settle();
        chk("R3", "jump never stalls", {31'd0, stall}, 0);
        @(negedge clk); id_jump = 0; settle();
        chk("R3", "plain instr never stalls", {31'd0, stall}, 0);
    endtask

    task automatic t_jump();
        @(negedge clk); idle();
        id_pc4 = 32'hA000_0040; id_jidx = 26'h0123456; id_jump = 1; settle();
        chk("R6", "jump flush", {31'd0, if_flush}, 1);
        chk("R6", "jump pc_sel", {30'd0, pc_sel}, 2);
        chk("R6", "jump target", redirect_pc, 32'hA048_D158);
        @(negedge clk); id_beq = 1; id_rs_val = 1; id_rt_val = 2; settle();
        chk("R6", "jump beats branch", {30'd0, pc_sel}, 2);
    endtask

    task automatic t_target_always();
        @(negedge clk); idle();
        id_pc4 = 32'h0040_0000; id_imm = 16'h8000; settle();
        chk("R9", "target for non-branch", redirect_pc, 32'h003E_0000);
        chk("R8", "non-branch seq", {30'd0, pc_sel}, 0);
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        t_reset_idle();
        @(negedge clk); rst = 1'b0;
        t_reset_idle();
        t_forward_selects();
        t_zero_reg();
        t_compare_forwarded();
        t_stall_priority();
        t_jump();
        t_target_always();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule